// File: doc/BRIEF.md
# Configuration Power-Up Start Sequencer

This block decides when a device may begin loading its configuration after power-up or after a reprogram request. While the active-low program request is held low, it sweeps a modeled configuration memory, issuing one clear write per clock and starting the sweep again each time it reaches the top address. When the request goes high, it runs exactly one more full sweep from address zero and then stops writing.

The shared init line is modeled as an open-drain pin. The block has a pull-low enable output, and the pin's level comes back in on a separate input. The block pulls the line low for the whole clearing phase. After the final sweep it releases the line and waits for as long as some other device keeps it low. On the first cycle it sees the line high, it latches the mode-select inputs. A slave then signals start at once. A master first waits a fixed settling interval, derived from the clock frequency, so that every device further down the chain has seen the line high. A new program request in any state sends the block straight back to clearing.

Top module: `cfg_start_seq`

## Requirements
- R1: During and after a synchronous active-high reset, the block is in the clearing phase: `clr_we`=1, `clr_addr`=0, `init_pull_low`=1, `cfg_start`=0, `cfg_ready`=0 and `mode_q`=0.
- R2: While `prog_req_n` is low, one clear write is issued per cycle. The address rises by one each cycle and goes from DEPTH-1 back to 0 without a gap.
- R3: When `prog_req_n` is seen high during clearing, the next cycle starts a fresh sweep at address 0. That sweep issues exactly DEPTH writes (addresses 0 to DEPTH-1), after which `clr_we` stays 0.
- R4: `init_pull_low` is 1 in every cycle in which `clr_we` is 1 and is 0 once the final sweep has ended.
- R5: A low on `prog_req_n` in any state gives, on the next cycle, `clr_we`=1, `clr_addr`=0 (or the next address if the block was already clearing), `init_pull_low`=1 and `cfg_ready`=0.
- R6: After the final sweep, the block holds while `init_sense` is low, with no start pulse and `cfg_ready`=0.
- R7: `mode_q` loads `mode_sel` only on the first cycle in which `init_sense` is seen high after the final sweep. At all other times `mode_q` is unchanged, whatever `mode_sel` does.
- R8: A slave mode (`mode_sel[0]`=1) gives `cfg_start`=1 and `cfg_ready`=1 in the cycle right after the capture. `cfg_start` is high for exactly one cycle and `cfg_ready` stays high.
- R9: A master mode (`mode_sel[0]`=0) delays `cfg_start` and `cfg_ready` by WAIT_CYC more cycles than the slave case, where WAIT_CYC = (CLK_HZ/1e6)*WAIT_US, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req_n | input | 1 | Program request, active low |
| init_sense | input | 1 | Sensed level of the open-drain init line |
| mode_sel | input | MODE_W | Mode-select inputs; bit 0 = 0 means master |
| init_pull_low | output | 1 | Drive-low enable for the init line |
| clr_we | output | 1 | Clear write strobe to the configuration memory |
| clr_addr | output | $clog2(DEPTH) | Address being cleared |
| mode_q | output | MODE_W | Captured mode |
| cfg_ready | output | 1 | Ready to load configuration (level) |
| cfg_start | output | 1 | One-cycle start-of-configuration pulse |

## Verification
The bound checker watches, on every cycle, these relations:
- A low request forces the pull-low enable and clears ready.
- The start pulse lasts a single cycle.
- Start never coincides with the line being pulled low.
- The captured mode changes only after a cycle in which the request and the init line were both high.

Some properties span many cycles and depend on where a sweep was interrupted: the exact sweep length after release, the wrap of the address, the extra master settling count, and aborts in the middle of the final sweep or the master wait. Only the bench's scenarios, run against a cycle model, can show those.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,  // repeated sweeps while request is low
    ST_FINAL = 3'd1,  // one full sweep after release
    ST_HOLD  = 3'd2,  // wait for init line to read high
    ST_MWAIT = 3'd3,  // master settling interval
    ST_DONE  = 3'd4   // ready to load
  } seq_state_t;

  localparam int MASTER_BIT = 0;

  function automatic logic is_clearing(input seq_state_t s);
    return (s == ST_CLEAR) || (s == ST_FINAL);
  endfunction

endpackage

// File: rtl/cfgseq_addr_ctr.sv
module cfgseq_addr_ctr #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      addr <= '0;
    end else if (step) begin
      addr <= at_last ? '0 : addr + 1'b1;
    end
  end

endmodule

// File: rtl/cfgseq_wait_ctr.sv
module cfgseq_wait_ctr #(
  parameter int CYCLES = 50000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
    end else if (run && !expired) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq #(
  parameter int DEPTH   = 1024,
  parameter int MODE_W  = 3,
  parameter int CLK_HZ  = 200_000_000,
  parameter int WAIT_US = 250,
  localparam int AW       = $clog2(DEPTH),
  localparam int RAW_WAIT = (CLK_HZ / 1_000_000) * WAIT_US,
  localparam int WAIT_CYC = (RAW_WAIT < 1) ? 1 : RAW_WAIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req_n,
  input  logic              init_sense,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              init_pull_low,
  output logic              clr_we,
  output logic [AW-1:0]     clr_addr,
  output logic [MODE_W-1:0] mode_q,
  output logic              cfg_ready,
  output logic              cfg_start
);

  import cfgseq_pkg::*;

  seq_state_t st, nxt;
  logic restart, step, at_last;
  logic t_load, t_expired, capture;
  logic want_master;

  assign want_master = (mode_sel[MASTER_BIT] == 1'b0);

  cfgseq_addr_ctr #(.DEPTH(DEPTH)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (step),
    .addr    (clr_addr),
    .at_last (at_last)
  );

  cfgseq_wait_ctr #(.CYCLES(WAIT_CYC)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .run     (st == ST_MWAIT),
    .expired (t_expired)
  );

  always_comb begin
    nxt     = st;
    restart = 1'b0;
    step    = 1'b0;
    t_load  = 1'b0;
    capture = 1'b0;
    if (!prog_req_n) begin
      nxt     = ST_CLEAR;
      restart = (st != ST_CLEAR);
      step    = (st == ST_CLEAR);
    end else begin
      case (st)
        ST_CLEAR: begin
          nxt     = ST_FINAL;
          restart = 1'b1;
        end
        ST_FINAL: begin
          step = 1'b1;
          if (at_last) nxt = ST_HOLD;
        end
        ST_HOLD: begin
          if (init_sense) begin
            capture = 1'b1;
            t_load  = want_master;
            nxt     = want_master ? ST_MWAIT : ST_DONE;
          end
        end
        ST_MWAIT: begin
          if (t_expired) nxt = ST_DONE;
        end
        ST_DONE: nxt = ST_DONE;
        default: nxt = ST_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_CLEAR;
      init_pull_low <= 1'b1;
      clr_we        <= 1'b1;
      cfg_start     <= 1'b0;
      cfg_ready     <= 1'b0;
      mode_q        <= '0;
    end else begin
      st            <= nxt;
      init_pull_low <= is_clearing(nxt);
      clr_we        <= is_clearing(nxt);
      cfg_start     <= (nxt == ST_DONE) && (st != ST_DONE);
      cfg_ready     <= (nxt == ST_DONE);
      if (capture) mode_q <= mode_sel;
    end
  end

endmodule

// File: rtl/cfg_start_seq_chk.sv
module cfg_start_seq_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_req_n,
  input logic              init_sense,
  input logic              init_pull_low,
  input logic              cfg_ready,
  input logic              cfg_start,
  input logic [MODE_W-1:0] mode_q
);

  // R5: request low pulls init low and drops ready on the next cycle
  a_r5_req_pulls_init: assert property (@(posedge clk) disable iff (rst)
    !prog_req_n |=> (init_pull_low && !cfg_ready));

  // R8: start is a single-cycle pulse
  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    cfg_start |=> !cfg_start);

  // R4: no start while the init line is being pulled low
  a_r4_start_not_pulling: assert property (@(posedge clk) disable iff (rst)
    cfg_start |-> !init_pull_low);

  // R7: mode changes only after a cycle with request and init both high
  a_r7_mode_capture_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> ($past(init_sense) && $past(prog_req_n)));

  // R9: ready only reached once the line is released
  a_r9_ready_released: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> !init_pull_low);

endmodule

bind cfg_start_seq cfg_start_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .prog_req_n    (prog_req_n),
  .init_sense    (init_sense),
  .init_pull_low (init_pull_low),
  .cfg_ready     (cfg_ready),
  .cfg_start     (cfg_start),
  .mode_q        (mode_q)
);

// File: tb/sim_cfg_start_seq.sv
module sim_cfg_start_seq;

  localparam int DEPTH   = 8;
  localparam int MODE_W  = 3;
  localparam int CLK_HZ  = 1_000_000;
  localparam int WAIT_US = 12;
  localparam int WAITC   = 12;
  localparam int AW      = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_req_n = 1'b0;
  logic ext_hold = 1'b1;
  logic [MODE_W-1:0] mode_sel = 3'b001;
  logic init_sense;
  logic init_pull_low, clr_we, cfg_ready, cfg_start;
  logic [AW-1:0] clr_addr;
  logic [MODE_W-1:0] mode_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // open-drain line: low if this block or the outside pulls it
  assign init_sense = !init_pull_low && !ext_hold;

  cfg_start_seq #(
    .DEPTH(DEPTH), .MODE_W(MODE_W), .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)
  ) u0 (
    .clk(clk), .rst(rst), .prog_req_n(prog_req_n), .init_sense(init_sense),
    .mode_sel(mode_sel), .init_pull_low(init_pull_low), .clr_we(clr_we),
    .clr_addr(clr_addr), .mode_q(mode_q), .cfg_ready(cfg_ready),
    .cfg_start(cfg_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct {
    logic we; int addr; logic pull; logic start; logic ready; int mode;
  } exp_t;
  exp_t q[$];

  int m_st = 0;  // 0 clear, 1 final, 2 hold, 3 mwait, 4 done
  int m_addr = 0;
  int m_cnt = 0;
  int m_mode = 0;
  logic m_start = 1'b0;

  always @(posedge clk) begin
    exp_t e;
    m_start = 1'b0;
    if (rst) begin
      m_st = 0; m_addr = 0; m_cnt = 0; m_mode = 0;
    end else if (!prog_req_n) begin
      m_addr = (m_st == 0) ? (m_addr + 1) % DEPTH : 0;
      m_st = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_addr = 0; end
        1: begin
          if (m_addr == DEPTH - 1) m_st = 2;
          m_addr = (m_addr + 1) % DEPTH;
        end
        2: if (init_sense) begin
          m_mode = int'(mode_sel);
          if (mode_sel[0] == 1'b0) begin m_st = 3; m_cnt = WAITC - 1; end
          else begin m_st = 4; m_start = 1'b1; end
        end
        3: if (m_cnt == 0) begin m_st = 4; m_start = 1'b1; end
           else m_cnt = m_cnt - 1;
        default: ;
      endcase
    end
    e.we = (m_st <= 1); e.addr = m_addr; e.pull = (m_st <= 1);
    e.start = m_start; e.ready = (m_st == 4); e.mode = m_mode;
    q.push_back(e);
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2/R3", "clr_we", int'(clr_we), int'(e.we));
      chk("R2/R3", "clr_addr", int'(clr_addr), e.addr);
      chk("R4/R5", "init_pull_low", int'(init_pull_low), int'(e.pull));
      chk("R8/R9", "cfg_start", int'(cfg_start), int'(e.start));
      chk("R6/R9", "cfg_ready", int'(cfg_ready), int'(e.ready));
      chk("R7", "mode_q", int'(mode_q), e.mode);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_to_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cfg_start && n < 200);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int n;
    cycles(3);
    // R1: reset state
    chk("R1", "clr_we", int'(clr_we), 1);
    chk("R1", "clr_addr", int'(clr_addr), 0);
    chk("R1", "init_pull_low", int'(init_pull_low), 1);
    chk("R1", "cfg_start", int'(cfg_start), 0);
    chk("R1", "cfg_ready", int'(cfg_ready), 0);
    chk("R1", "mode_q", int'(mode_q), 0);
    rst = 1'b0;
    cycles(2 * DEPTH + 5);            // R2: sweeps wrap while held low
    prog_req_n = 1'b1;                // R3: final sweep, init held outside
    cycles(DEPTH / 2);
    mode_sel = 3'b110;                // R7: ignored during the sweep
    cycles(DEPTH + 6);
    mode_sel = 3'b101;                // R7: ignored while held
    cycles(3);
    // R6: holding, no start, line released by block
    chk("R6", "cfg_ready held", int'(cfg_ready), 0);
    chk("R6", "init_pull_low held", int'(init_pull_low), 0);
    chk("R7", "mode_q before capture", int'(mode_q), 0);
    mode_sel = 3'b011;
    ext_hold = 1'b0;                  // R8: slave capture
    count_to_start(n);
    chk("R8", "slave start latency", n, 1);
    chk("R7", "captured mode", int'(mode_q), 3);
    mode_sel = 3'b000;
    cycles(4);
    chk("R7", "mode after capture", int'(mode_q), 3);
    chk("R8", "ready stays", int'(cfg_ready), 1);
    prog_req_n = 1'b0;                // R5: abort from done
    cycles(1);
    chk("R5", "ready dropped", int'(cfg_ready), 0);
    chk("R5", "pull asserted", int'(init_pull_low), 1);
    chk("R5", "addr restart", int'(clr_addr), 0);
    cycles(2);
    mode_sel = 3'b010;                // R9: master
    prog_req_n = 1'b1;
    count_to_start(n);
    chk("R9", "master start latency", n, DEPTH + WAITC + 2);
    chk("R7", "master mode", int'(mode_q), 2);
    cycles(3);
    prog_req_n = 1'b0;                // R5: abort during final sweep
    cycles(2);
    prog_req_n = 1'b1;
    cycles(3);
    prog_req_n = 1'b0;
    cycles(1);
    chk("R5", "abort in final sweep", int'(clr_addr), 0);
    prog_req_n = 1'b1;
    cycles(DEPTH + 5);                // into master wait
    prog_req_n = 1'b0;                // R5: abort during master wait
    cycles(1);
    chk("R5", "abort in master wait", int'(init_pull_low), 1);
    mode_sel = 3'b111;
    prog_req_n = 1'b1;
    count_to_start(n);
    chk("R8", "slave after abort", n, DEPTH + 2);
    cycles(3);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule